// File: doc/BRIEF.md
# Two-Wire ID EEPROM Command Engine

This block is the command engine of a small identification memory that answers on a two-wire serial bus. It watches the already synchronized clock and data lines, finds START and STOP conditions, and takes in a device address byte and then a word address byte. It then either collects up to one page of write data or streams bytes back to the master. It acknowledges each accepted byte by pulling the data line low through the ninth clock. The storage array sits outside the block and is reached through a plain address, read-data and write-strobe port.

Writes are gated by a separate write-enable input. That input must be high when the START of a write command is seen and must stay high without a break until its STOP. Any dip discards the whole command. Accepted bytes are held in a page buffer and are committed to the array only after the STOP. A busy window of a fixed number of system clocks then begins, and during that window the device address is not acknowledged. Each acknowledged device address also sends a one-cycle pulse to the surrounding mode controller.

Top module: `twi_id_eeprom`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` low), `mem_we_o` is low and `cmd_ack_o` is low.
- R2: A START is a falling data line while the clock is high. A STOP is a rising data line while the clock is high. A repeated START begins a new command, and after a STOP the data line is released.
- R3: A device byte whose upper 7 bits equal `DEV_ID` (default 7'h50) is acknowledged by driving the data line low during the ninth clock. Bit 0 selects the direction, 1 = read. Any other device byte is not acknowledged, and the rest of that command is ignored.
- R4: Each acknowledged device byte gives exactly one `cmd_ack_o` pulse one system clock long. An unacknowledged byte gives none.
- R5: In a write command the second byte is the word address. Its low 7 bits set the current address, and the byte is acknowledged.
- R6: Data bytes reach the array only after the STOP, and only if `wr_en_i` was high at the START and at every clock through the STOP. Otherwise the command is dropped, the array is unchanged and no busy window starts.
- R7: Within one write command, data bytes fill the 8-byte page of the word address. The low 3 address bits wrap inside the page, so a ninth byte replaces the first byte of the command.
- R8: For `BUSY_CYCLES` system clocks after a committing STOP, the device byte is not acknowledged. Once the window has expired it is acknowledged again.
- R9: In a read, each byte is sent MSB first. The data line changes only after a falling clock edge. The address advances by one per byte and wraps from 7Fh to 00h, and the read ends when the master does not acknowledge.
- R10: A read command without a word address starts at the current address, which is one past the last byte read or written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (bus level) |
| wr_en_i | input | 1 | Write-enable level (dual-use clock pin) |
| sda_oe_o | output | 1 | Pull the data line low when high |
| mem_addr_o | output | ADDR_W | Array address |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o` |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| cmd_ack_o | output | 1 | Pulse on acknowledged device address |

## Verification
The bench keeps the default 7-bit address, 3-bit page offset and device identifier 7'h50, but builds the block with `BUSY_CYCLES` set to 300. With that value a write-then-address attempt lands inside the busy window, and a later attempt lands after it expires, within a short run. A ten-byte page write starting near the end of a page exercises the wrap and the overwrite of earlier bytes. A read that starts at 7Eh crosses the top of the array. Two write commands are also sent with the write-enable low for part of the command or for all of it.

// File: rtl/twi_id_pkg.sv
package twi_id_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDAT,
    ST_RDAT
  } twi_state_e;
endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int unsigned CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8
endmodule

// File: rtl/twi_id_eeprom.sv
module twi_id_eeprom
  import twi_id_pkg::*;
#(
  parameter logic [6:0]  DEV_ID      = 7'h50,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned OFS_W       = 3,
  parameter int unsigned BUSY_CYCLES = 2_000_000  // must be >= page size
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_en_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              cmd_ack_o
);
  localparam int unsigned PAGE_N = 1 << OFS_W;
  localparam int unsigned PG_W   = ADDR_W - OFS_W;

  logic rise_w, fall_w, start_w, stop_w, busy_w, commit_go;

  twi_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(rise_w), .scl_fall_o(fall_w), .start_o(start_w), .stop_o(stop_w)
  );

  twi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(commit_go), .busy_o(busy_w)
  );

  twi_state_e         state_q;
  logic [3:0]         cnt_q;
  logic [7:0]         sh_q;
  logic               rd_q, we_ok_q, oe_q, ack_q, commit_q;
  logic [ADDR_W-1:0]  cur_q;
  logic [PG_W-1:0]    page_q;
  logic [PAGE_N-1:0]  valid_q, cmask_q;
  logic [OFS_W-1:0]   cidx_q;
  logic [7:0]         pbuf_q [PAGE_N];
  logic               pbuf_we;

  assign commit_go = stop_w & we_ok_q & wr_en_i & (|valid_q);
  assign pbuf_we   = fall_w & ~start_w & ~stop_w & (state_q == ST_WDAT) & (cnt_q == 4'd8);

  always_ff @(posedge clk_i) begin
    if (pbuf_we) pbuf_q[cur_q[OFS_W-1:0]] <= sh_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_q     <= 1'b0;
      we_ok_q  <= 1'b0;
      oe_q     <= 1'b0;
      ack_q    <= 1'b0;
      commit_q <= 1'b0;
      cur_q    <= '0;
      page_q   <= '0;
      valid_q  <= '0;
      cmask_q  <= '0;
      cidx_q   <= '0;
    end else begin
      ack_q   <= 1'b0;
      we_ok_q <= we_ok_q & wr_en_i;
      if (commit_q) begin
        cidx_q <= cidx_q + 1'b1;
        if (cidx_q == OFS_W'(PAGE_N - 1)) commit_q <= 1'b0;
      end
      if (start_w) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        valid_q <= '0;
        we_ok_q <= wr_en_i;
      end else if (stop_w) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        valid_q <= '0;
        if (commit_go) begin
          commit_q <= 1'b1;
          cidx_q   <= '0;
          cmask_q  <= valid_q;
        end
      end else if (state_q != ST_IDLE) begin
        if (rise_w) begin
          if (cnt_q < 4'd8) begin
            cnt_q <= cnt_q + 4'd1;
            if (state_q != ST_RDAT) sh_q <= {sh_q[6:0], sda_i};
          end else if (cnt_q == 4'd8) begin
            // master NACK ends a read
            if (state_q == ST_RDAT && sda_i) state_q <= ST_IDLE;
            else cnt_q <= 4'd9;
          end
        end else if (fall_w) begin
          if (cnt_q == 4'd8 && state_q != ST_RDAT) begin
            unique case (state_q)
              ST_DEV: begin
                if (sh_q[7:1] == DEV_ID && !busy_w) begin
                  oe_q  <= 1'b1;
                  rd_q  <= sh_q[0];
                  ack_q <= 1'b1;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_WORD: begin
                oe_q   <= 1'b1;
                cur_q  <= sh_q[ADDR_W-1:0];
                page_q <= sh_q[ADDR_W-1:OFS_W];
              end
              ST_WDAT: begin
                oe_q <= 1'b1;
                valid_q[cur_q[OFS_W-1:0]] <= 1'b1;
                cur_q[OFS_W-1:0] <= cur_q[OFS_W-1:0] + 1'b1;
              end
              default: ;
            endcase
          end else if (cnt_q == 4'd8) begin
            oe_q  <= 1'b0;
            cur_q <= cur_q + 1'b1;
          end else if (cnt_q == 4'd9) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
            unique case (state_q)
              ST_DEV: begin
                if (rd_q) begin
                  state_q <= ST_RDAT;
                  sh_q    <= mem_rdata_i;
                  oe_q    <= ~mem_rdata_i[7];
                end else begin
                  state_q <= ST_WORD;
                end
              end
              ST_WORD: state_q <= ST_WDAT;
              ST_RDAT: begin
                sh_q <= mem_rdata_i;
                oe_q <= ~mem_rdata_i[7];
              end
              default: ;
            endcase
          end else if (state_q == ST_RDAT && cnt_q != '0) begin
            sh_q <= {sh_q[6:0], 1'b0};
            oe_q <= ~sh_q[6];
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign cmd_ack_o   = ack_q;
  assign mem_we_o    = commit_q & cmask_q[cidx_q];
  assign mem_wdata_o = pbuf_q[cidx_q];
  assign mem_addr_o  = commit_q ? {page_q, cidx_q} : cur_q;

  AST_OE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(fall_w || start_w || stop_w)); // R9
  AST_RELEASE_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_w) |-> !sda_oe_o); // R2
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |=> !cmd_ack_o); // R4
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> !busy_w); // R8
  AST_WRITE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_w); // R6
endmodule

// File: tb/twi_id_eeprom_bench.sv
module twi_id_eeprom_bench;
  localparam int Q = 4;
  localparam int BUSY = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wr_en = 1'b0;
  logic sda_oe, mem_we, cmd_ack;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  twi_id_eeprom #(.BUSY_CYCLES(BUSY)) u_twi_id_eeprom (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .wr_en_i(wr_en),
    .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .cmd_ack_o(cmd_ack)
  );

  logic [7:0] mem [128];
  logic [7:0] ref_m [128];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int checks = 0, errors = 0, ack_pulses = 0;
  bit done = 0;
  always @(posedge clk) if (cmd_ack) ack_pulses++;

  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] obs_byte;
  event obs_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(obs_ev);
    if (exp_q.size() == 0) chk(1'b0, "scoreboard underrun", obs_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(obs_byte == e, t, obs_byte, e);
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1; w(2*Q); scl = 0; w(Q);
    end
    sda_m = 1; w(Q); scl = 1; w(Q); ack = ~sda_bus; w(Q); scl = 0; w(Q);
  endtask

  task automatic recv_byte(input bit m_ack, input string tag);
    logic [7:0] b;
    bit stable_ok = 1;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      logic s1;
      w(Q); scl = 1; w(Q); s1 = sda_bus; b[i] = s1; w(Q);
      if (sda_bus != s1) stable_ok = 0;
      scl = 0;
    end
    chk(stable_ok, "R9 data stable while clock high", 0, 1);
    obs_byte = b;
    -> obs_ev;
    sda_m = ~m_ack; w(Q); scl = 1; w(2*Q); scl = 0; w(Q); sda_m = 1;
  endtask

  task automatic expect_ack(input logic [7:0] b, input bit exp, input string tag);
    bit a;
    send_byte(b, a);
    chk(a == exp, tag, a, exp);
  endtask

  // random read: set address, repeated start, read n bytes
  task automatic read_at(input int addr, input int n, input string tag);
    expect_ack(8'hA0, 1, "R3 write device ack");
    expect_ack(8'(addr), 1, "R5 word address ack");
    bus_start();
    expect_ack(8'hA1, 1, "R3 read device ack");
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_m[(addr + i) % 128]);
      tag_q.push_back(tag);
      recv_byte(i != n - 1, tag);
    end
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'((i * 37 + 11) % 256);
      ref_m[i] = 8'((i * 37 + 11) % 256);
    end
    w(3); rst_n = 1; w(2);
    // R1 reset state
    chk(sda_oe == 0, "R1 sda released", sda_oe, 0);
    chk(mem_we == 0, "R1 no write", mem_we, 0);
    chk(cmd_ack == 0, "R1 no ack pulse", cmd_ack, 0);

    // R2 R3 R4 R9 random read of three bytes
    begin
      int p0;
      p0 = ack_pulses;
      bus_start();
      read_at(16, 3, "R9 sequential read");
      w(2);
      chk(ack_pulses == p0 + 2, "R4 one pulse per acked device byte", ack_pulses, p0 + 2);
    end

    // R10 current address read continues at 19
    bus_start();
    expect_ack(8'hA1, 1, "R10 read device ack");
    exp_q.push_back(ref_m[19]); tag_q.push_back("R10 current address read");
    recv_byte(0, "R10");
    bus_stop();

    // R3 R4 foreign device byte
    begin
      int p0;
      p0 = ack_pulses;
      bus_start();
      expect_ack(8'hA6, 0, "R3 foreign device no ack");
      expect_ack(8'h10, 0, "R3 rest of command ignored");
      bus_stop();
      w(2);
      chk(ack_pulses == p0, "R4 no pulse without ack", ack_pulses, p0);
    end

    // R6 R8 byte write, then busy nack, then expiry
    wr_en = 1; w(2);
    bus_start();
    expect_ack(8'hA0, 1, "R6 write device ack");
    expect_ack(8'h20, 1, "R5 word ack");
    expect_ack(8'h3C, 1, "R6 data ack");
    bus_stop();
    wr_en = 0;
    ref_m[32] = 8'h3C;
    bus_start();
    expect_ack(8'hA1, 0, "R8 no ack while busy");
    bus_stop();
    w(BUSY + 50);
    bus_start();
    read_at(32, 1, "R6 byte write committed");
    chk(mem[32] == 8'h3C, "R6 array written", mem[32], 8'h3C);

    // R7 ten-byte page write starting at 2Dh
    wr_en = 1; w(2);
    bus_start();
    expect_ack(8'hA0, 1, "R7 device ack");
    expect_ack(8'h2D, 1, "R7 word ack");
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'(8'h80 + i * 3);
      expect_ack(d, 1, "R7 page data ack");
      ref_m[8'h28 + (5 + i) % 8] = d;
    end
    bus_stop();
    wr_en = 0;
    w(BUSY + 50);
    bus_start();
    read_at(8'h28, 9, "R7 page wrap contents");

    // R6 write enable dropped mid command
    wr_en = 1; w(2);
    bus_start();
    expect_ack(8'hA0, 1, "R6 device ack");
    expect_ack(8'h40, 1, "R6 word ack");
    fork
      begin w(40); wr_en = 0; w(4); wr_en = 1; end
      expect_ack(8'h55, 1, "R6 data ack");
    join
    bus_stop();
    wr_en = 0;
    bus_start();
    read_at(8'h40, 1, "R6 discarded write leaves array");
    chk(mem[64] == ref_m[64], "R6 array unchanged", mem[64], ref_m[64]);

    // R6 write enable low the whole time
    bus_start();
    expect_ack(8'hA0, 1, "R6 device ack enable low");
    expect_ack(8'h41, 1, "R6 word ack enable low");
    expect_ack(8'h99, 1, "R6 data ack enable low");
    bus_stop();
    bus_start();
    expect_ack(8'hA0, 1, "R6 no busy after dropped write");
    bus_stop();
    chk(mem[65] == ref_m[65], "R6 array unchanged enable low", mem[65], ref_m[65]);

    // R9 wrap from 7Fh to 00h
    bus_start();
    read_at(8'h7E, 3, "R9 read wrap");
    bus_start();
    expect_ack(8'hA1, 1, "R10 device ack after wrap");
    exp_q.push_back(ref_m[1]); tag_q.push_back("R10 address after wrap");
    recv_byte(0, "R10");
    bus_stop();

    w(10);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    chk(sda_oe == 0, "R2 released after stop", sda_oe, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule